// File: doc/BRIEF.md
# Banked Array Conflict Tracker

This block tracks which banks of a multi-bank storage array are occupied by in-flight accesses. An index maps to a bank by taking the index modulo the bank count. A single query port tells the requester, within the same cycle, whether an access to a given index may start. A group of reservation ports claims a bank for a fixed access latency. Several ports exist so that one requester can reserve the same entry for, say, a read and a write in one cycle.

Each bank is a two-state machine. `BANK_IDLE` means the bank is free. `BANK_BUSY` means it is held and carries a countdown of the remaining held cycles. The transitions are:
- *accept*: `BANK_IDLE` to `BANK_BUSY` when a reservation is taken and the latency exceeds one.
- *countdown*: `BANK_BUSY` to `BANK_BUSY` while more than one held cycle remains.
- *release*: `BANK_BUSY` to `BANK_IDLE` after the last held cycle.

Queries and reservations in one cycle are all judged against the bank state as it stood at the start of that cycle. If a reservation hits a bank that is already held, or collides in the same cycle with a different index on the same bank, an error bit is raised for that port during that cycle. Two ports that reserve the same index in the same cycle are treated as one harmless reservation.

Top module: `banked_conflict_tracker`

## Requirements
- R1: The bank of an index is the index modulo `NUM_BANKS`. With one bank, every index maps to bank 0.
- R2: `qry_grant` depends only on the bank state at the start of the cycle. A reservation accepted in the same cycle does not lower it in that cycle.
- R3: A reservation accepted in cycle t holds its bank for cycles t to t+LATENCY-1. Queries to that bank are refused in cycles t+1 to t+LATENCY-1 and granted again from cycle t+LATENCY.
- R4: A reservation to the same bank issued in cycle t+LATENCY is accepted without error.
- R5: A valid reservation to a bank that is held at the start of the cycle raises that port's `rsv_err` bit in that cycle. It leaves the existing hold window unchanged, neither extended nor restarted.
- R6: Two ports that reserve the same index in the same cycle raise no error and create a single hold window.
- R7: Two ports that reserve different indices on the same free bank in the same cycle resolve by port number. The lowest-numbered valid port takes the bank, and each later port gets its `rsv_err` bit. The hold window is that of the winner.
- R8: Reservations to different free banks in the same cycle are all accepted, each with its own window.
- R9: With `LATENCY` = 0, `qry_grant` is always 1, `rsv_err` is always 0, and reservations change no state.
- R10: Synchronous active-low reset returns every bank to `BANK_IDLE`, so all queries are granted after reset.
- R11: An `rsv_err` bit is only ever set for a port whose `rsv_valid` bit is set. An index on a port whose valid bit is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| qry_idx | input | IDX_W | Index whose bank is queried |
| qry_grant | output | 1 | 1 when an access to the queried bank may start this cycle |
| rsv_valid | input | RSV_PORTS | Per-port reservation request; bit p belongs to port p |
| rsv_idx | input | RSV_PORTS*IDX_W | Per-port index; port p uses bits [p*IDX_W +: IDX_W] |
| rsv_err | output | RSV_PORTS | Per-port illegal-reservation pulse, valid in the request cycle |

## Verification
A bank machine that stays in `BANK_BUSY` too long, or leaves it too early, shows up on `qry_grant` at the query in cycle t+LATENCY-1 or t+LATENCY after the reservation. This is one cycle after the mistake, since the bench queries each of those cycles. A hold window that a rejected or duplicate reservation wrongly restarted shows up as a refused grant in cycle t+LATENCY. A wrong bank mapping or a wrong port priority shows up in the same cycle, as an unexpected `rsv_err` bit or a grant on the wrong bank.

// File: rtl/tracker_pkg.sv
package tracker_pkg;

    typedef enum logic {
        BANK_IDLE = 1'b0,
        BANK_BUSY = 1'b1
    } bank_state_e;

    function automatic int bank_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int count_width(input int lat);
        return (lat > 1) ? $clog2(lat) : 1;
    endfunction

endpackage

// File: rtl/bank_map.sv
module bank_map #(
    parameter int NUM_BANKS = 4,
    parameter int IDX_W     = 8,
    parameter int BANK_W    = 2
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [BANK_W-1:0] bank
);

    localparam bit IS_POW2 = ((NUM_BANKS & (NUM_BANKS - 1)) == 0);

    generate
        if (NUM_BANKS == 1) begin : g_single
            logic [IDX_W-1:0] unused_idx;
            assign unused_idx = idx;
            assign bank = '0;
        end else if (IS_POW2) begin : g_slice
            assign bank = idx[BANK_W-1:0];
        end else begin : g_modulo
            logic [IDX_W-1:0] rem;
            assign rem  = idx % IDX_W'(NUM_BANKS);
            assign bank = rem[BANK_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/bank_slot.sv
module bank_slot
    import tracker_pkg::*;
#(
    parameter int LATENCY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    output logic busy
);

    localparam int CNT_W = count_width(LATENCY);
    localparam int LOAD  = (LATENCY > 0) ? LATENCY - 1 : 0;

    bank_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BANK_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions: accept, countdown, release
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            BANK_IDLE: begin
                if (take && (LOAD != 0)) begin
                    state_d = BANK_BUSY;
                    cnt_d   = CNT_W'(LOAD);
                end
            end
            BANK_BUSY: begin
                if (cnt_q <= CNT_W'(1)) begin
                    state_d = BANK_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: begin
                state_d = BANK_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy = (state_q == BANK_BUSY);
    end

    assert_no_take_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (state_q == BANK_IDLE));

    assert_release_on_time_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BANK_BUSY && cnt_q == CNT_W'(1)) |=> (state_q == BANK_IDLE));

    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BANK_IDLE && !take) |=> (state_q == BANK_IDLE));

    assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BANK_BUSY) |-> (cnt_q != '0 && cnt_q <= CNT_W'(LOAD)));

endmodule

// File: rtl/rsv_resolve.sv
module rsv_resolve #(
    parameter int NUM_BANKS = 4,
    parameter int RSV_PORTS = 2,
    parameter int IDX_W     = 8,
    parameter int BANK_W    = 2,
    parameter int LATENCY   = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [RSV_PORTS-1:0]        rsv_valid,
    input  logic [RSV_PORTS*IDX_W-1:0]  rsv_idx,
    input  logic [RSV_PORTS*BANK_W-1:0] rsv_bank,
    input  logic [NUM_BANKS-1:0]        bank_busy,
    output logic [RSV_PORTS-1:0]        rsv_err,
    output logic [NUM_BANKS-1:0]        bank_take
);

    logic             found;
    logic [IDX_W-1:0] owner_idx;
    logic [BANK_W-1:0] my_bank;

    always_comb begin
        rsv_err   = '0;
        bank_take = '0;
        found     = 1'b0;
        owner_idx = '0;
        my_bank   = '0;
        for (int p = 0; p < RSV_PORTS; p++) begin
            found     = 1'b0;
            owner_idx = '0;
            my_bank   = rsv_bank[p*BANK_W +: BANK_W];
            // the lowest valid port on this bank owns it this cycle
            for (int q = 0; q < p; q++) begin
                if (!found && rsv_valid[q] && rsv_bank[q*BANK_W +: BANK_W] == my_bank) begin
                    found     = 1'b1;
                    owner_idx = rsv_idx[q*IDX_W +: IDX_W];
                end
            end
            if (rsv_valid[p] && (LATENCY != 0)) begin
                if (bank_busy[my_bank]) begin
                    rsv_err[p] = 1'b1;
                end else if (found) begin
                    if (owner_idx != rsv_idx[p*IDX_W +: IDX_W]) begin
                        rsv_err[p] = 1'b1;
                    end
                end else begin
                    bank_take[my_bank] = 1'b1;
                end
            end
        end
    end

    assert_take_needs_free_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_take & bank_busy) == '0);

    assert_err_only_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_err & ~rsv_valid) == '0);

endmodule

// File: rtl/banked_conflict_tracker.sv
module banked_conflict_tracker
    import tracker_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int LATENCY   = 3,
    parameter int IDX_W     = 8,
    parameter int RSV_PORTS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IDX_W-1:0]           qry_idx,
    output logic                       qry_grant,
    input  logic [RSV_PORTS-1:0]       rsv_valid,
    input  logic [RSV_PORTS*IDX_W-1:0] rsv_idx,
    output logic [RSV_PORTS-1:0]       rsv_err
);

    localparam int BANK_W = bank_width(NUM_BANKS);

    logic [BANK_W-1:0]           qry_bank;
    logic [RSV_PORTS*BANK_W-1:0] port_bank;
    logic [NUM_BANKS-1:0]        bank_busy;
    logic [NUM_BANKS-1:0]        bank_take;

    bank_map #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W), .BANK_W(BANK_W)) u_qry_map (
        .idx  (qry_idx),
        .bank (qry_bank)
    );

    generate
        for (genvar p = 0; p < RSV_PORTS; p++) begin : g_port_map
            bank_map #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W), .BANK_W(BANK_W)) u_map (
                .idx  (rsv_idx[p*IDX_W +: IDX_W]),
                .bank (port_bank[p*BANK_W +: BANK_W])
            );
        end

        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            bank_slot #(.LATENCY(LATENCY)) u_slot (
                .clk   (clk),
                .rst_n (rst_n),
                .take  (bank_take[b]),
                .busy  (bank_busy[b])
            );
        end
    endgenerate

    rsv_resolve #(
        .NUM_BANKS (NUM_BANKS),
        .RSV_PORTS (RSV_PORTS),
        .IDX_W     (IDX_W),
        .BANK_W    (BANK_W),
        .LATENCY   (LATENCY)
    ) u_resolve (
        .clk       (clk),
        .rst_n     (rst_n),
        .rsv_valid (rsv_valid),
        .rsv_idx   (rsv_idx),
        .rsv_bank  (port_bank),
        .bank_busy (bank_busy),
        .rsv_err   (rsv_err),
        .bank_take (bank_take)
    );

    always_comb begin
        qry_grant = (LATENCY == 0) || !bank_busy[qry_bank];
    end

    generate
        if (LATENCY == 0) begin : g_chk_zero
            assert_zero_lat_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
                qry_grant && (rsv_err == '0));
        end
        if (LATENCY > 1) begin : g_chk_hold
            assert_refuse_after_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (rsv_valid[0] && !rsv_err[0]) |=>
                    (!qry_grant || qry_bank != $past(port_bank[BANK_W-1:0])));
        end
    endgenerate

endmodule

// File: tb/banked_conflict_tracker_tb_top.sv
module banked_conflict_tracker_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 8;
    localparam int NV         = 21;

    // fields: [32:29] req, [28:27] valid, [26:19] idx0, [18:11] idx1,
    //         [10:3] query, [2] expected grant, [1:0] expected err
    localparam logic [32:0] VEC [NV] = '{
        {4'd10, 2'b00, 8'd0,  8'd0, 8'd5,   1'b1, 2'b00}, // R10 idle
        {4'd2,  2'b01, 8'd5,  8'd0, 8'd5,   1'b1, 2'b00}, // R2 same-cycle query granted
        {4'd3,  2'b00, 8'd0,  8'd0, 8'd9,   1'b0, 2'b00}, // R3 t+1
        {4'd5,  2'b01, 8'd13, 8'd0, 8'd1,   1'b0, 2'b01}, // R5 busy bank
        {4'd4,  2'b01, 8'd1,  8'd0, 8'd5,   1'b1, 2'b00}, // R4 t+L accepted
        {4'd3,  2'b00, 8'd0,  8'd0, 8'd9,   1'b0, 2'b00}, // R3
        {4'd3,  2'b00, 8'd0,  8'd0, 8'd13,  1'b0, 2'b00}, // R3
        {4'd3,  2'b00, 8'd0,  8'd0, 8'd9,   1'b1, 2'b00}, // R3 released
        {4'd6,  2'b11, 8'd6,  8'd6, 8'd2,   1'b1, 2'b00}, // R6 duplicate
        {4'd6,  2'b00, 8'd0,  8'd0, 8'd2,   1'b0, 2'b00}, // R6
        {4'd6,  2'b00, 8'd0,  8'd0, 8'd10,  1'b0, 2'b00}, // R6
        {4'd6,  2'b00, 8'd0,  8'd0, 8'd6,   1'b1, 2'b00}, // R6 single window
        {4'd7,  2'b11, 8'd3,  8'd7, 8'd3,   1'b1, 2'b10}, // R7 port 1 loses
        {4'd7,  2'b00, 8'd0,  8'd0, 8'd7,   1'b0, 2'b00}, // R7
        {4'd5,  2'b10, 8'd0,  8'd3, 8'd0,   1'b1, 2'b10}, // R5 port 1 on busy bank
        {4'd7,  2'b00, 8'd0,  8'd0, 8'd3,   1'b1, 2'b00}, // R7 window not extended
        {4'd8,  2'b11, 8'd4,  8'd2, 8'd4,   1'b1, 2'b00}, // R8 two banks
        {4'd11, 2'b00, 8'd4,  8'd0, 8'd4,   1'b0, 2'b00}, // R11 invalid idx ignored
        {4'd11, 2'b00, 8'd0,  8'd2, 8'd2,   1'b0, 2'b00}, // R11 / R8
        {4'd1,  2'b00, 8'd0,  8'd0, 8'd255, 1'b1, 2'b00}, // R1 high index bank 3
        {4'd8,  2'b00, 8'd0,  8'd0, 8'd6,   1'b1, 2'b00}  // R8 bank 2 released
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [IDX_W-1:0]     qry_idx = '0;
    logic [1:0]           rsv_valid = '0;
    logic [2*IDX_W-1:0]   rsv_idx = '0;
    logic                 grant, z_grant, o_grant, t_grant;
    logic [1:0]           err, z_err, o_err, t_err;
    int                   n_checks = 0;
    int                   n_fail = 0;
    bit                   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_conflict_tracker #(.NUM_BANKS(4), .LATENCY(3), .IDX_W(IDX_W), .RSV_PORTS(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .qry_idx(qry_idx), .qry_grant(grant),
        .rsv_valid(rsv_valid), .rsv_idx(rsv_idx), .rsv_err(err));

    banked_conflict_tracker #(.NUM_BANKS(4), .LATENCY(0), .IDX_W(IDX_W), .RSV_PORTS(2)) dut_zero (
        .clk(clk), .rst_n(rst_n), .qry_idx(qry_idx), .qry_grant(z_grant),
        .rsv_valid(rsv_valid), .rsv_idx(rsv_idx), .rsv_err(z_err));

    banked_conflict_tracker #(.NUM_BANKS(1), .LATENCY(2), .IDX_W(IDX_W), .RSV_PORTS(2)) dut_one (
        .clk(clk), .rst_n(rst_n), .qry_idx(qry_idx), .qry_grant(o_grant),
        .rsv_valid(rsv_valid), .rsv_idx(rsv_idx), .rsv_err(o_err));

    banked_conflict_tracker #(.NUM_BANKS(3), .LATENCY(2), .IDX_W(IDX_W), .RSV_PORTS(2)) dut_three (
        .clk(clk), .rst_n(rst_n), .qry_idx(qry_idx), .qry_grant(t_grant),
        .rsv_valid(rsv_valid), .rsv_idx(rsv_idx), .rsv_err(t_err));

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // drive just after the falling edge; outputs are checked a quarter period later
    task automatic drive(input logic [1:0] v, input logic [7:0] i0, input logic [7:0] i1,
                         input logic [7:0] q);
        @(negedge clk);
        rsv_valid = v;
        rsv_idx   = {i1, i0};
        qry_idx   = q;
        #(CLK_PERIOD/4);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        rsv_valid = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // reset state: every bank granted (R10)
        for (int b = 0; b < 4; b++) begin
            drive(2'b00, 8'd0, 8'd0, 8'(b));
            check("R10", "grant after reset", int'(grant), 1);
        end

        for (int k = 0; k < NV; k++) begin
            drive(VEC[k][28:27], VEC[k][26:19], VEC[k][18:11], VEC[k][10:3]);
            check($sformatf("R%0d", int'(VEC[k][32:29])), $sformatf("vector %0d grant", k),
                  int'(grant), int'(VEC[k][2]));
            check($sformatf("R%0d", int'(VEC[k][32:29])), $sformatf("vector %0d err", k),
                  int'(err), int'(VEC[k][1:0]));
        end

        // R10: reset in the middle of a hold window
        drive(2'b01, 8'd1, 8'd0, 8'd1);
        do_reset();
        drive(2'b00, 8'd0, 8'd0, 8'd1);
        check("R10", "grant after mid-window reset", int'(grant), 1);

        // R9: zero latency instance
        drive(2'b11, 8'd5, 8'd9, 8'd5);
        check("R9", "zero-latency err on colliding ports", int'(z_err), 0);
        check("R9", "zero-latency grant same cycle", int'(z_grant), 1);
        drive(2'b00, 8'd0, 8'd0, 8'd5);
        check("R9", "zero-latency grant next cycle", int'(z_grant), 1);

        // R1: single bank, every index lands in bank 0
        do_reset();
        drive(2'b01, 8'd7, 8'd0, 8'd4);
        check("R1", "single-bank grant before hold", int'(o_grant), 1);
        drive(2'b00, 8'd0, 8'd0, 8'd4);
        check("R1", "single-bank other index refused", int'(o_grant), 0);
        drive(2'b00, 8'd0, 8'd0, 8'd4);
        check("R1", "single-bank released", int'(o_grant), 1);

        // R1: three banks, modulo mapping (5 and 8 share bank 2, 6 is bank 0)
        do_reset();
        drive(2'b01, 8'd5, 8'd0, 8'd0);
        drive(2'b00, 8'd0, 8'd0, 8'd8);
        check("R1", "mod-3 same bank refused", int'(t_grant), 0);
        drive(2'b01, 8'd5, 8'd0, 8'd0);
        drive(2'b00, 8'd0, 8'd0, 8'd6);
        check("R1", "mod-3 other bank granted", int'(t_grant), 1);

        done = 1'b1;
    end

    initial begin
        int cycles = 0;
        while (!done && cycles < 5000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule